// File: doc/BRIEF.md
# Multi-Batch Cluster Mode Configurator

This block groups the four execution engines of one processing element into clusters. It also steers their local routers onto the shared horizontal and vertical data paths. A configuration word arrives over a valid/ready handshake, and a two-bit batch field is taken out of it. That field selects one of three groupings:

- every engine on its own;
- two clusters of two engines;
- one cluster of four engines.

The block turns the chosen grouping into an 8-bit link-select word S1..S8 for the routers. The new word takes effect only after every engine has acknowledged the current configuration period, and a one-cycle done pulse marks the switch.

Instruction and activation words enter on two independent ports, each carrying a destination index. They are spread to the engines through a two-level controller tree: a root decides which leaf controllers take part, and each leaf drives two engines. In clustered groupings, one write reaches every member engine of the addressed cluster in the same cycle and with the same data. This gives a cluster a single shared instruction stream.

Top module: `cluster_mode_cfg`

## Requirements
- R1: During and directly after reset the block is in the following state:
  - `link_sel` is 0 and the active grouping is single-batch;
  - `cfg_ready` is 1;
  - `config_done` and `cfg_err` are 0;
  - no engine valid output is high.
- R2: Bit k-1 of `link_sel` carries Sk. In single-batch grouping (field 00), `link_sel` is 8'h00, which satisfies S1==S5, S3==S7, S2==S4 and S6==S8.
- R3: In two-batch grouping (field 01), only S4 and S8 are set (`link_sel` = 8'h88). This satisfies S1==S5, S3==S7, S2!=S4 and S6!=S8.
- R4: In four-batch grouping (field 10), S4, S5, S7 and S8 are set, giving S1..S8 = 0001-1011 (`link_sel` = 8'hD8). This satisfies S1!=S5, S3!=S7, S2!=S4 and S6!=S8.
- R5: The batch field is `cfg_word[BF_LSB+1:BF_LSB]`. The value 11 is illegal:
  - the configuration is consumed;
  - `cfg_err` pulses high in the following cycle;
  - `link_sel` and the active grouping stay as they were;
  - `cfg_ready` stays 1.
- R6: A configuration is taken when `cfg_valid` and `cfg_ready` are both high. After a legal one, `cfg_ready` stays low until it has been applied, and any `cfg_valid` seen meanwhile is ignored.
- R7: Acknowledgement handling works as follows:
  - Starting the cycle after a legal configuration is taken, each bit of `eng_ack` is remembered, in any order and in any mix of cycles.
  - In the cycle after the last missing bit arrives, `link_sel` and the active grouping take the new value and `config_done` is high for one cycle.
  - Before that cycle `link_sel` is unchanged.
  - Acks that arrive while no configuration is pending are ignored.
- R8: In single-batch grouping, an instruction write reaches only engine `ins_dst`, one cycle after the write.
- R9: In two-batch grouping, `ins_dst[0]` picks cluster 0 (engines 0 and 1) or cluster 1 (engines 2 and 3), and `ins_dst[1]` is ignored. Both member engines show valid and the same data one cycle after the write.
- R10: In four-batch grouping, an instruction write reaches all four engines with the same data one cycle after the write.
- R11: The activation port follows the same routing as R8–R10, using `act_dst`, and is independent of the instruction port. Engine data outputs are meaningful only while the matching valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Ready to take a configuration |
| cfg_word | input | CW | Task configuration word holding the batch field |
| eng_ack | input | 4 | Per-engine acknowledgement of the configuration period |
| link_sel | output | 8 | Router link-select word, bit k-1 = Sk |
| config_done | output | 1 | One-cycle pulse when a new grouping is applied |
| cfg_err | output | 1 | One-cycle pulse after an illegal batch field |
| ins_valid | input | 1 | Instruction write valid |
| ins_dst | input | 2 | Engine index or cluster index |
| ins_data | input | IW | Instruction word |
| act_valid | input | 1 | Activation write valid |
| act_dst | input | 2 | Engine index or cluster index |
| act_data | input | AW | Activation word |
| eng_ins_valid | output | 4 | Per-engine instruction valid |
| eng_ins_data | output | 4*IW | Per-engine instruction, engine k at [k*IW +: IW] |
| eng_act_valid | output | 4 | Per-engine activation valid |
| eng_act_data | output | 4*AW | Per-engine activation, engine k at [k*AW +: AW] |

## Verification
The bench builds the block with IW=16, AW=8, CW=8 and BF_LSB=2. Placing the batch field away from bit 0, with noise in the other bits, shows that the field is extracted and not taken from the low bits. The wide and distinct instruction and activation widths let a write on each port be told apart even when both hit the same engine in the same cycle. With these values the bench can reach every grouping switch, the ack orders (split and all at once), an illegal field, ignored out-of-period acks, and `ins_dst[1]` being ignored in two-batch grouping.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int NENG  = 4;
  localparam int NLEAF = NENG / 2;
  localparam int LINKW = 8;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_QUAD   = 2'b10
  } bmode_e;

  // Bit k-1 carries Sk.
  function automatic logic [LINKW-1:0] link_word(bmode_e m);
    logic [LINKW-1:0] w;
    w = '0;
    case (m)
      MODE_PAIR: begin w[3] = 1'b1; w[7] = 1'b1; end
      MODE_QUAD: begin w[3] = 1'b1; w[4] = 1'b1; w[6] = 1'b1; w[7] = 1'b1; end
      default:   w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cmc_mode_ctrl.sv
module cmc_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int CW     = 8,
  parameter int BF_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CW-1:0]    cfg_word,
  input  logic [NENG-1:0]  eng_ack,
  output logic [LINKW-1:0] link_sel,
  output bmode_e           mode,
  output logic             config_done,
  output logic             cfg_err
);
  logic [1:0]      field;
  logic            pend_q;
  bmode_e          pmode_q;
  logic [NENG-1:0] acks_q;
  logic            all_in;

  assign field     = cfg_word[BF_LSB +: 2];
  assign all_in    = &(acks_q | eng_ack);
  assign cfg_ready = !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pmode_q     <= MODE_SINGLE;
      acks_q      <= '0;
      link_sel    <= '0;
      mode        <= MODE_SINGLE;
      config_done <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      config_done <= 1'b0;
      cfg_err     <= 1'b0;
      if (pend_q) begin
        acks_q <= acks_q | eng_ack;
        if (all_in) begin
          link_sel    <= link_word(pmode_q);
          mode        <= pmode_q;
          pend_q      <= 1'b0;
          config_done <= 1'b1;
        end
      end else if (cfg_valid) begin
        if (field == 2'b11) begin
          cfg_err <= 1'b1;
        end else begin
          pmode_q <= bmode_e'(field);
          pend_q  <= 1'b1;
          acks_q  <= '0;
        end
      end
    end
  end

  // R2
  a_r2_single_rules: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_SINGLE |-> (link_sel[0] == link_sel[4] && link_sel[2] == link_sel[6] &&
                             link_sel[1] == link_sel[3] && link_sel[5] == link_sel[7]));
  // R3
  a_r3_pair_rules: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_PAIR |-> (link_sel[0] == link_sel[4] && link_sel[2] == link_sel[6] &&
                           link_sel[1] != link_sel[3] && link_sel[5] != link_sel[7]));
  // R4
  a_r4_quad_rules: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_QUAD |-> (link_sel[0] != link_sel[4] && link_sel[2] != link_sel[6] &&
                           link_sel[1] != link_sel[3] && link_sel[5] != link_sel[7]));
  // R5
  a_r5_err_keeps_word: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> ($stable(link_sel) && $stable(mode) && cfg_ready));
  // R7
  a_r7_change_on_done: assert property (@(posedge clk) disable iff (rst)
    (link_sel != $past(link_sel)) |-> config_done);
  // R7 / R6
  a_r7_done_after_pending: assert property (@(posedge clk) disable iff (rst)
    config_done |-> $past(!cfg_ready));
endmodule

// File: rtl/cmc_dispatch_root.sv
module cmc_dispatch_root
  import cmc_pkg::*;
(
  input  bmode_e           mode,
  input  logic             in_valid,
  input  logic [1:0]       in_dst,
  output logic [NLEAF-1:0] leaf_en,
  output logic             bcast,
  output logic             lidx
);
  always_comb begin
    leaf_en = '0;
    bcast   = 1'b0;
    lidx    = 1'b0;
    if (in_valid) begin
      case (mode)
        MODE_SINGLE: begin
          leaf_en[in_dst[1]] = 1'b1;
          lidx = in_dst[0];
        end
        MODE_PAIR: begin
          leaf_en[in_dst[0]] = 1'b1;
          bcast = 1'b1;
        end
        MODE_QUAD: begin
          leaf_en = '1;
          bcast   = 1'b1;
        end
        default: leaf_en = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmc_leaf.sv
module cmc_leaf #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           bcast,
  input  logic           lidx,
  input  logic [W-1:0]   din,
  output logic [1:0]     vld,
  output logic [2*W-1:0] dout
);
  for (genvar j = 0; j < 2; j++) begin : g_eng
    logic hit;
    assign hit = en && (bcast || (lidx == 1'(j)));
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[j]          <= 1'b0;
        dout[j*W +: W]  <= '0;
      end else begin
        vld[j] <= hit;
        if (hit) dout[j*W +: W] <= din;
      end
    end
  end
endmodule

// File: rtl/cluster_mode_cfg.sv
module cluster_mode_cfg
  import cmc_pkg::*;
#(
  parameter int IW     = 16,
  parameter int AW     = 8,
  parameter int CW     = 8,
  parameter int BF_LSB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CW-1:0]    cfg_word,
  input  logic [NENG-1:0]  eng_ack,
  output logic [LINKW-1:0] link_sel,
  output logic             config_done,
  output logic             cfg_err,
  input  logic             ins_valid,
  input  logic [1:0]       ins_dst,
  input  logic [IW-1:0]    ins_data,
  input  logic             act_valid,
  input  logic [1:0]       act_dst,
  input  logic [AW-1:0]    act_data,
  output logic [NENG-1:0]  eng_ins_valid,
  output logic [NENG*IW-1:0] eng_ins_data,
  output logic [NENG-1:0]  eng_act_valid,
  output logic [NENG*AW-1:0] eng_act_data
);
  bmode_e           mode_w;
  logic [NLEAF-1:0] ins_en, act_en;
  logic             ins_bc, act_bc, ins_li, act_li;

  cmc_mode_ctrl #(.CW(CW), .BF_LSB(BF_LSB)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .eng_ack(eng_ack), .link_sel(link_sel), .mode(mode_w),
    .config_done(config_done), .cfg_err(cfg_err)
  );

  cmc_dispatch_root u_ins_root (
    .mode(mode_w), .in_valid(ins_valid), .in_dst(ins_dst),
    .leaf_en(ins_en), .bcast(ins_bc), .lidx(ins_li)
  );

  cmc_dispatch_root u_act_root (
    .mode(mode_w), .in_valid(act_valid), .in_dst(act_dst),
    .leaf_en(act_en), .bcast(act_bc), .lidx(act_li)
  );

  for (genvar l = 0; l < NLEAF; l++) begin : g_leaf
    cmc_leaf #(.W(IW)) u_ins_leaf (
      .clk(clk), .rst(rst), .en(ins_en[l]), .bcast(ins_bc), .lidx(ins_li),
      .din(ins_data), .vld(eng_ins_valid[2*l +: 2]), .dout(eng_ins_data[2*l*IW +: 2*IW])
    );
    cmc_leaf #(.W(AW)) u_act_leaf (
      .clk(clk), .rst(rst), .en(act_en[l]), .bcast(act_bc), .lidx(act_li),
      .din(act_data), .vld(eng_act_valid[2*l +: 2]), .dout(eng_act_data[2*l*AW +: 2*AW])
    );
  end

  // R8
  a_r8_single_one_engine: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && mode_w == MODE_SINGLE) |=> ($countones(eng_ins_valid) == 1));
  // R9
  a_r9_pair_cluster: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && mode_w == MODE_PAIR) |=>
      (eng_ins_valid == 4'b0011 || eng_ins_valid == 4'b1100));
  // R10
  a_r10_quad_all: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && mode_w == MODE_QUAD) |=> (&eng_ins_valid));
  // R11
  a_r11_act_idle: assert property (@(posedge clk) disable iff (rst)
    !act_valid |=> (eng_act_valid == '0));
endmodule

// File: tb/cluster_mode_cfg_tb.sv
module cluster_mode_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;
  localparam int AW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [CW-1:0] cfg_word = '0;
  logic [3:0] eng_ack = '0;
  logic [7:0] link_sel;
  logic config_done, cfg_err;
  logic ins_valid = 1'b0;
  logic [1:0] ins_dst = '0;
  logic [IW-1:0] ins_data = '0;
  logic act_valid = 1'b0;
  logic [1:0] act_dst = '0;
  logic [AW-1:0] act_data = '0;
  logic [3:0] eng_ins_valid, eng_act_valid;
  logic [4*IW-1:0] eng_ins_data;
  logic [4*AW-1:0] eng_act_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_mode_cfg #(.IW(IW), .AW(AW), .CW(CW), .BF_LSB(2)) dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .eng_ack(eng_ack), .link_sel(link_sel),
    .config_done(config_done), .cfg_err(cfg_err),
    .ins_valid(ins_valid), .ins_dst(ins_dst), .ins_data(ins_data),
    .act_valid(act_valid), .act_dst(act_dst), .act_data(act_data),
    .eng_ins_valid(eng_ins_valid), .eng_ins_data(eng_ins_data),
    .eng_act_valid(eng_act_valid), .eng_act_data(eng_act_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model: grouping 0 single, 1 pair, 2 quad.
  int m_mode, m_pm;
  bit m_pend, m_done, m_err;
  logic [3:0] m_acks, m_iv, m_av;
  logic [7:0] m_link;
  logic [IW-1:0] m_id [4];
  logic [AW-1:0] m_ad [4];

  function automatic bit reaches(int md, logic [1:0] dst, int k);
    if (md == 0) return (k == int'(dst));
    if (md == 1) return ((k / 2) == int'(dst[0]));
    return 1'b1;
  endfunction

  function automatic logic [7:0] sword(int md);
    logic [7:0] w = '0;       // bit k-1 = Sk
    if (md == 1) begin w[4-1] = 1; w[8-1] = 1; end
    if (md == 2) begin w[4-1] = 1; w[5-1] = 1; w[7-1] = 1; w[8-1] = 1; end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_pm = 0; m_pend = 0; m_done = 0; m_err = 0;
      m_acks = 0; m_iv = 0; m_av = 0; m_link = 0;
      for (int k = 0; k < 4; k++) begin m_id[k] = 0; m_ad[k] = 0; end
    end else begin
      m_done = 0; m_err = 0;
      for (int k = 0; k < 4; k++) begin
        m_iv[k] = ins_valid && reaches(m_mode, ins_dst, k);
        if (m_iv[k]) m_id[k] = ins_data;
        m_av[k] = act_valid && reaches(m_mode, act_dst, k);
        if (m_av[k]) m_ad[k] = act_data;
      end
      if (m_pend) begin
        m_acks = m_acks | eng_ack;
        if (m_acks == 4'hF) begin
          m_link = sword(m_pm); m_mode = m_pm; m_pend = 0; m_done = 1;
        end
      end else if (cfg_valid) begin
        int f;
        f = int'(cfg_word[3:2]);
        if (f == 3) m_err = 1;
        else begin m_pm = f; m_pend = 1; m_acks = 0; end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(link_sel == m_link, "R2 R3 R4 R7 link_sel", 64'(link_sel), 64'(m_link));
      chk(config_done == m_done, "R7 config_done", 64'(config_done), 64'(m_done));
      chk(cfg_err == m_err, "R5 cfg_err", 64'(cfg_err), 64'(m_err));
      chk(cfg_ready == !m_pend, "R6 cfg_ready", 64'(cfg_ready), 64'(!m_pend));
      chk(eng_ins_valid == m_iv, "R8 R9 R10 ins valid", 64'(eng_ins_valid), 64'(m_iv));
      chk(eng_act_valid == m_av, "R11 act valid", 64'(eng_act_valid), 64'(m_av));
      for (int k = 0; k < 4; k++) begin
        if (m_iv[k]) chk(eng_ins_data[k*IW +: IW] == m_id[k], "R8 R9 R10 ins data",
                         64'(eng_ins_data[k*IW +: IW]), 64'(m_id[k]));
        if (m_av[k]) chk(eng_act_data[k*AW +: AW] == m_ad[k], "R11 act data",
                         64'(eng_act_data[k*AW +: AW]), 64'(m_ad[k]));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] f, input logic [3:0] ack_now);
    cfg_valid = 1; cfg_word = {4'hA, f, 2'b11}; eng_ack = ack_now;
    @(negedge clk);
    cfg_valid = 0; cfg_word = '0; eng_ack = 0;
  endtask

  task automatic ack(input logic [3:0] a);
    eng_ack = a;
    @(negedge clk);
    eng_ack = 0;
  endtask

  task automatic wr(input logic iv, input logic [1:0] id, input logic [IW-1:0] idat,
                    input logic av, input logic [1:0] ad, input logic [AW-1:0] adat);
    ins_valid = iv; ins_dst = id; ins_data = idat;
    act_valid = av; act_dst = ad; act_data = adat;
    @(negedge clk);
    ins_valid = 0; act_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(link_sel == 0, "R1 link_sel", 64'(link_sel), 0);
    chk(cfg_ready == 1, "R1 cfg_ready", 64'(cfg_ready), 1);
    chk(config_done == 0 && cfg_err == 0, "R1 done/err", 64'({config_done, cfg_err}), 0);
    chk(eng_ins_valid == 0 && eng_act_valid == 0, "R1 valids",
        64'({eng_ins_valid, eng_act_valid}), 0);
    rst = 0;
    idle(1);
    // R8 / R11 single-batch dispatch, acks with nothing pending ignored (R7)
    for (int d = 0; d < 4; d++) wr(1, 2'(d), 16'h1000 + 16'(d), 1, 2'(3 - d), 8'h40 + 8'(d));
    ack(4'hF);
    chk(link_sel == 8'h00, "R2 single word", 64'(link_sel), 0);
    // R6 / R7 two-batch with split acks; acks in the accept cycle ignored
    cfg(2'b01, 4'hF);
    chk(cfg_ready == 0, "R6 ready low while pending", 64'(cfg_ready), 0);
    ack(4'b0100);
    cfg(2'b10, 4'b0000);         // R6 ignored while pending
    ack(4'b1001);
    idle(2);
    chk(link_sel == 8'h00, "R7 word held before last ack", 64'(link_sel), 0);
    ack(4'b0010);
    chk(config_done == 1, "R7 done pulse", 64'(config_done), 1);
    chk(link_sel == 8'h88, "R3 pair word", 64'(link_sel), 64'h88);
    idle(1);
    // R9 pair dispatch; dst bit1 ignored
    for (int d = 0; d < 4; d++) wr(1, 2'(d), 16'h2200 + 16'(d), 1, 2'(d + 1), 8'h50 + 8'(d));
    // R5 illegal field
    cfg(2'b11, 4'h0);
    chk(cfg_err == 1, "R5 err pulse", 64'(cfg_err), 1);
    chk(link_sel == 8'h88, "R5 word kept", 64'(link_sel), 64'h88);
    wr(1, 2'd1, 16'h2AAA, 0, 0, 0);
    // R4 four-batch, acks all at once
    cfg(2'b10, 4'h0);
    ack(4'hF);
    chk(link_sel == 8'hD8, "R4 quad word", 64'(link_sel), 64'hD8);
    // R10 quad dispatch, R11 act alongside
    wr(1, 2'd2, 16'h3333, 1, 2'd0, 8'h77);
    wr(1, 2'd0, 16'h3444, 0, 0, 0);
    wr(0, 0, 0, 1, 2'd3, 8'h88);
    // Back to single-batch
    cfg(2'b00, 4'hF);
    ack(4'b0011);
    ack(4'b1100);
    chk(link_sel == 8'h00, "R2 single again", 64'(link_sel), 0);
    wr(1, 2'd2, 16'h4242, 1, 2'd2, 8'h42);
    wr(1, 2'd3, 16'h4343, 1, 2'd0, 8'h43);
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule